// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Front End

This block is the address-generation and fetch stage of a simple sequential core whose instructions are all one 32-bit word. It holds the program counter and the instruction register. The PC drives the address of an external instruction memory, and that memory returns the addressed word in the same cycle. The IR captures that word when its load strobe is high. The PC takes a new value when its own load strobe is high.

The next PC comes from two selects in a row. The operand select feeds the adder either the constant instruction size (4) or the sign-extended jump offset. The result select then picks either the adder output or an absolute jump address. Together they give three modes: step to the next word, jump relative to the PC, and jump to an absolute address. The jump field comes from the low 26 bits of the held instruction, shifted left by two. A surrounding controller sequences the strobes. This block only carries out the data movement.

Top module: `fetch_front`

## Requirements
- R1: A synchronous active-high reset sets the PC and the IR to zero at the next rising clock edge, so the opcode and target outputs also read zero.
- R2: With pc_load high, operand select 0 (constant) and result select 0 (sum), the PC becomes PC + 4 after the edge, wrapping modulo 2^32 (0xFFFFFFFC steps to 0).
- R3: With pc_load high, operand select 1 (jump) and result select 0, the PC becomes PC plus the jump offset. The offset is IR bits 25:0 followed by two zero bits, a 28-bit value sign-extended from its top bit.
- R4: With pc_load high and result select 1, the PC becomes PC bits 31:28 followed by IR bits 25:0 and two zero bits, whatever the operand select is.
- R5: With pc_load low, the PC keeps its value whatever the two selects and the IR strobe are.
- R6: With ir_load high, the IR takes the memory read word at the edge. With ir_load low, the IR keeps its value.
- R7: When both strobes are high in one cycle, the IR receives the word addressed by the old PC while the PC moves to its next value.
- R8: The opcode output is IR bits 31:26 and the target output is IR bits 25:0.
- R9: The instruction memory address output always equals the PC register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_load | input | 1 | PC update strobe |
| ir_load | input | 1 | Instruction register capture strobe |
| opnd_sel | input | 1 | Adder operand: 0 constant 4, 1 sign-extended jump offset |
| result_sel | input | 1 | New PC: 0 adder sum, 1 absolute jump address |
| imem_addr | output | 32 | Instruction memory byte address (current PC) |
| imem_rdata | input | 32 | Combinational read data of the instruction memory |
| ir | output | 32 | Held instruction word |
| opcode | output | 6 | Opcode field of the held instruction |
| target | output | 26 | Jump target field of the held instruction |

## Verification
Every result appears one clock edge after its stimulus. The PC, the IR and the fields sliced from it are all registers fed by the strobes, the selects and the memory word present at that edge. The bench drives inputs on the falling edge and updates its reference model for the rising edge in between. It compares every output at the next falling edge, so each compare sits exactly one register stage after the inputs it depends on. Directed steps before the pseudo-random run reach the wrap of the PC past 0xFFFFFFFC through a negative relative jump. They also cover the cycle with both strobes high.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned OPC_W    = 6;
  localparam int unsigned TGT_W    = XLEN - OPC_W;
  localparam int unsigned WORD_SH  = 2;
  localparam int unsigned JUMP_W   = TGT_W + WORD_SH;

  typedef enum logic {
    OPND_STEP = 1'b0,
    OPND_JUMP = 1'b1
  } opnd_sel_e;

  typedef enum logic {
    NEXT_SUM  = 1'b0,
    NEXT_ABS  = 1'b1
  } next_sel_e;

endpackage

// File: rtl/fetch_jump_gen.sv
module fetch_jump_gen #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned TGT_W   = 26,
  parameter int unsigned WORD_SH = 2
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [TGT_W-1:0] target,
  output logic [XLEN-1:0]  rel_off,
  output logic [XLEN-1:0]  abs_addr
);

  localparam int unsigned JW = TGT_W + WORD_SH;

  logic [JW-1:0] scaled;

  always_comb begin
    scaled = {target, {WORD_SH{1'b0}}};
  end

  generate
    if (XLEN > JW) begin : g_wide
      always_comb begin
        rel_off  = {{(XLEN-JW){scaled[JW-1]}}, scaled};
        abs_addr = {pc[XLEN-1:JW], scaled};
      end
    end else begin : g_narrow
      always_comb begin
        rel_off  = scaled[XLEN-1:0];
        abs_addr = scaled[XLEN-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/fetch_pc_path.sv
module fetch_pc_path
  import fetch_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned STEP_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] rel_off,
  input  logic [XLEN-1:0] abs_addr,
  input  opnd_sel_e       opnd_sel,
  input  next_sel_e       next_sel,
  output logic [XLEN-1:0] pc_next
);

  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] sum;

  // first select: adder operand
  always_comb begin
    unique case (opnd_sel)
      OPND_JUMP: operand = rel_off;
      default:   operand = STEP;
    endcase
    sum = pc + operand;
  end

  // second select: new PC value
  always_comb begin
    unique case (next_sel)
      NEXT_ABS: pc_next = abs_addr;
      default:  pc_next = sum;
    endcase
  end

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= XLEN'(RESET_PC);
    else if (ld) q <= d;
  end

  // R5: PC holds without its strobe
  a_r5_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));

endmodule

// File: rtl/fetch_ir_reg.sv
module fetch_ir_reg #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned OPC_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic [XLEN-1:0]    d,
  output logic [XLEN-1:0]    q,
  output logic [OPC_W-1:0]   opc,
  output logic [XLEN-OPC_W-1:0] tgt
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end

  always_comb begin
    opc = q[XLEN-1:XLEN-OPC_W];
    tgt = q[XLEN-OPC_W-1:0];
  end

  // R6: capture the memory word on the strobe
  a_r6_ir_capture: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(d)));
  // R6: hold without the strobe
  a_r6_ir_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(q));

endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_load,
  input  logic              ir_load,
  input  logic              opnd_sel,
  input  logic              result_sel,
  output logic [XLEN-1:0]   imem_addr,
  input  logic [XLEN-1:0]   imem_rdata,
  output logic [XLEN-1:0]   ir,
  output logic [OPC_W-1:0]  opcode,
  output logic [TGT_W-1:0]  target
);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] rel_off;
  logic [XLEN-1:0] abs_addr;
  opnd_sel_e       osel;
  next_sel_e       nsel;

  always_comb begin
    osel = opnd_sel_e'(opnd_sel);
    nsel = next_sel_e'(result_sel);
  end

  fetch_jump_gen #(.XLEN(XLEN), .TGT_W(TGT_W), .WORD_SH(WORD_SH)) u_jump (
    .pc       (pc_q),
    .target   (target),
    .rel_off  (rel_off),
    .abs_addr (abs_addr)
  );

  fetch_pc_path #(.XLEN(XLEN), .STEP_BYTES(1 << WORD_SH)) u_path (
    .pc       (pc_q),
    .rel_off  (rel_off),
    .abs_addr (abs_addr),
    .opnd_sel (osel),
    .next_sel (nsel),
    .pc_next  (pc_d)
  );

  fetch_pc_reg #(.XLEN(XLEN), .RESET_PC(32'h0)) u_pc (
    .clk (clk),
    .rst (rst),
    .ld  (pc_load),
    .d   (pc_d),
    .q   (pc_q)
  );

  fetch_ir_reg #(.XLEN(XLEN), .OPC_W(OPC_W)) u_ir (
    .clk (clk),
    .rst (rst),
    .ld  (ir_load),
    .d   (imem_rdata),
    .q   (ir),
    .opc (opcode),
    .tgt (target)
  );

  always_comb imem_addr = pc_q;

  // R2: sequential step by one word
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (pc_load && !opnd_sel && !result_sel) |=> (imem_addr == $past(imem_addr) + 32'd4));
  // R3: relative jump adds the sign-extended scaled target
  a_r3_rel_jump: assert property (@(posedge clk) disable iff (rst)
    (pc_load && opnd_sel && !result_sel) |=>
      (imem_addr == $past(imem_addr) + {{(XLEN-JUMP_W){$past(target[TGT_W-1])}}, $past(target), 2'b00}));
  // R4: absolute jump keeps the upper PC bits
  a_r4_abs_jump: assert property (@(posedge clk) disable iff (rst)
    (pc_load && result_sel) |=>
      (imem_addr == {$past(imem_addr[XLEN-1:JUMP_W]), $past(target), 2'b00}));
  // R7: with both strobes the IR gets the word at the old PC
  a_r7_both_strobes: assert property (@(posedge clk) disable iff (rst)
    (pc_load && ir_load) |=> (ir == $past(imem_rdata)));

endmodule

// File: tb/fetch_front_test.sv
module fetch_front_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_load = 1'b0;
  logic        ir_load = 1'b0;
  logic        opnd_sel = 1'b0;
  logic        result_sel = 1'b0;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] ir;
  logic [5:0]  opcode;
  logic [25:0] target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] m_pc = 32'h0;
  logic [31:0] m_ir = 32'h0;

  always #5 clk = ~clk;

  fetch_front uut (
    .clk        (clk),
    .rst        (rst),
    .pc_load    (pc_load),
    .ir_load    (ir_load),
    .opnd_sel   (opnd_sel),
    .result_sel (result_sel),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .ir         (ir),
    .opcode     (opcode),
    .target     (target)
  );

  // computed memory contents, 64 words indexed by address bits 7:2
  function automatic logic [31:0] mem_word(input logic [5:0] idx);
    logic [31:0] h;
    if (idx == 6'd0) return {6'h02, 26'h3FF_FFFF};
    h = ({26'd0, idx} * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    return h;
  endfunction

  always_comb imem_rdata = mem_word(imem_addr[7:2]);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string pc_req, input string ir_req);
    check(pc_req, "pc", imem_addr, m_pc);
    check(ir_req, "ir", ir, m_ir);
    check("R8", "opcode", {26'd0, opcode}, {26'd0, m_ir[31:26]});
    check("R8", "target", {6'd0, target}, {6'd0, m_ir[25:0]});
  endtask

  // one cycle: drive at falling edge, model the rising edge, compare at next falling edge
  task automatic step(input bit pl, input bit il, input bit os, input bit rs);
    logic [31:0] word;
    logic [31:0] off;
    string pr;
    string irr;
    pc_load = pl; ir_load = il; opnd_sel = os; result_sel = rs;
    word = mem_word(m_pc[7:2]);
    off  = $signed({m_ir[25:0], 2'b00, 4'b0000}) >>> 4;
    if (!pl)      pr = "R5";
    else if (rs)  pr = "R4";
    else if (os)  pr = "R3";
    else          pr = "R2";
    irr = (pl && il) ? "R7" : "R6";
    @(posedge clk);
    if (il) m_ir = word;
    if (pl) begin
      if (rs)      m_pc = {m_pc[31:28], m_ir_prev_target(off), 2'b00};
      else if (os) m_pc = m_pc + off;
      else         m_pc = m_pc + 32'd4;
    end
    @(negedge clk);
    compare_all(pr, irr);
  endtask

  // absolute target from the offset computed before the IR update
  function automatic logic [25:0] m_ir_prev_target(input logic [31:0] off);
    return off[27:2];
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pc after reset", imem_addr, 32'h0);
    check("R1", "ir after reset", ir, 32'h0);
    check("R1", "opcode after reset", {26'd0, opcode}, 32'h0);
    check("R9", "imem_addr equals pc", imem_addr, m_pc);
    rst = 1'b0;

    // load word 0 (target all ones, offset -4) with PC held
    step(1'b0, 1'b1, 1'b1, 1'b0);
    // relative jump by -4 from 0: PC 0xFFFFFFFC
    step(1'b1, 1'b0, 1'b1, 1'b0);
    check("R3", "negative relative jump", imem_addr, 32'hFFFF_FFFC);
    // sequential step wraps to 0, both strobes: IR takes word at 0xFFFFFFFC (index 63)
    step(1'b1, 1'b1, 1'b0, 1'b0);
    check("R2", "wrap to zero", imem_addr, 32'h0);
    check("R7", "ir from old pc", ir, mem_word(6'd63));
    // absolute jump ignores operand select
    step(1'b1, 1'b0, 1'b1, 1'b1);
    check("R4", "absolute jump upper bits", {28'd0, imem_addr[31:28]}, 32'h0);
    // PC held with all selects toggled
    step(1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i == 2000) begin
        rst = 1'b1;
        pc_load = 1'b1; ir_load = 1'b1;
        @(posedge clk);
        m_pc = 32'h0; m_ir = 32'h0;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "pc after mid reset", imem_addr, 32'h0);
        check("R1", "ir after mid reset", ir, 32'h0);
      end
      step(r[0], r[1], r[2], r[3] & r[4]);
      check("R9", "imem_addr equals pc", imem_addr, m_pc);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule